// File: doc/BRIEF.md
# Stack, Program Counter and Status Flag Update Unit

This unit applies the register side effects that follow instruction execution in a small 8-bit processor core. It keeps an 8-bit stack pointer that addresses a fixed one-page hardware stack in memory, a 16-bit program counter, and an 8-bit status register. Decode and ALU logic sit outside the unit and drive its command strobes. The strobes cover pushing a byte, popping a byte, stepping the program counter past an instruction, taking a relative branch, and refreshing the zero and negative flags from a result byte.

The three lanes are independent and can all act in the same cycle. The stack lane handles push and pop, the program-counter lane handles branch and step, and the flag lane handles the flag refresh. Inside each lane only one command is accepted per cycle. Stack traffic uses a single memory port with a combinational address and strobes, and every access finishes in one cycle. The registered stack pointer, program counter and status register are visible on the outputs.

Top module: `post_exec_update`

## Requirements
- R1: While `rst_n` is low, the outputs hold their reset values: `sp_o`=0xFF, `pc_o`=0x0000, `status_o`=0x00, `pop_data_o`=0x00 and `pop_valid_o`=0.
- R2: In a cycle with `push_i` high, `mem_we_o` is high, `mem_addr_o` is 0x0100 plus the current `sp_o`, and `mem_wdata_o` equals `push_data_i`. At the next edge `sp_o` drops by one.
- R3: In a cycle with a pop accepted, `mem_re_o` is high and `mem_addr_o` is 0x0100 plus (`sp_o`+1 modulo 256). At the next edge `sp_o` rises by one, `pop_data_o` takes `mem_rdata_i`, and `pop_valid_o` is high for exactly that following cycle.
- R4: The stack pointer wraps modulo 256: a push at 0x00 gives 0xFF, and a pop at 0xFF gives 0x00 and reads address 0x0100.
- R5: When `push_i` and `pop_i` are both high, only the push is performed. `mem_re_o` stays low, `sp_o` drops by one only, and `pop_valid_o` is low in the next cycle.
- R6: A step (`adv_i` high, `branch_i` low) adds `adv_size_i`, a 2-bit count from 0 to 3, to `pc_o` at the next edge.
- R7: A taken branch (`branch_i` high) adds the two's-complement value of `br_off_i` plus 2 to `pc_o` at the next edge.
- R8: When `branch_i` and `adv_i` are both high, only the branch is applied.
- R9: The program counter wraps modulo 65536 in both directions.
- R10: A flag refresh (`flag_upd_i` high) sets `status_o` bit 1 (zero) when `result_i` is 0x00 and clears it otherwise.
- R11: A flag refresh copies `result_i` bit 7 into `status_o` bit 7 (negative).
- R12: A flag refresh leaves every `status_o` bit other than 1 and 7 unchanged. Without a refresh, `status_o` is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_i | input | 1 | Push `push_data_i` onto the stack |
| pop_i | input | 1 | Pop one byte from the stack |
| push_data_i | input | 8 | Byte to push |
| adv_i | input | 1 | Step the program counter |
| adv_size_i | input | 2 | Instruction length to step by |
| branch_i | input | 1 | Take a relative branch |
| br_off_i | input | 8 | Signed branch displacement |
| flag_upd_i | input | 1 | Refresh the zero and negative flags |
| result_i | input | 8 | Result byte for the flag refresh |
| mem_addr_o | output | 16 | Stack memory address |
| mem_we_o | output | 1 | Stack memory write strobe |
| mem_re_o | output | 1 | Stack memory read strobe |
| mem_wdata_o | output | 8 | Stack memory write data |
| mem_rdata_i | input | 8 | Stack memory read data, valid in the same cycle |
| sp_o | output | 8 | Stack pointer |
| pc_o | output | 16 | Program counter |
| status_o | output | 8 | Status register |
| pop_data_o | output | 8 | Most recently popped byte |
| pop_valid_o | output | 1 | `pop_data_o` was loaded at the last edge |

## Verification
The memory strobes, address and write data are combinational, so they are due in the cycle the command is driven. The bench checks them one nanosecond after driving the inputs, before the rising edge. `sp_o`, `pc_o`, `status_o`, `pop_data_o` and `pop_valid_o` each pass through one register, so they are due one edge after the command. They are compared at the next falling edge against a behavioural model that is updated right after each rising edge. The stimulus runs directed sequences for each wrap and priority case, followed by a random mix of commands.

// File: rtl/post_exec_update_pkg.sv
package post_exec_update_pkg;
    localparam int DATA_W  = 8;
    localparam int ADDR_W  = 16;
    localparam int Z_BIT   = 1;
    localparam int N_BIT   = 7;

    typedef struct packed {
        logic [DATA_W-1:0] sp;
        logic [DATA_W-1:0] pop_data;
        logic              pop_valid;
    } stack_state_t;

    typedef struct packed {
        logic [ADDR_W-1:0] pc;
    } pc_state_t;

    typedef struct packed {
        logic [DATA_W-1:0] status;
    } flag_state_t;
endpackage

// File: rtl/peu_stack_lane.sv
module peu_stack_lane
    import post_exec_update_pkg::*;
#(
    parameter logic [DATA_W-1:0] STACK_PAGE = 8'h01,
    parameter logic [DATA_W-1:0] SP_RESET   = 8'hFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic              pop_i,
    input  logic [DATA_W-1:0] push_data_i,
    input  logic [DATA_W-1:0] mem_rdata_i,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              mem_we_o,
    output logic              mem_re_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    output logic [DATA_W-1:0] sp_o,
    output logic [DATA_W-1:0] pop_data_o,
    output logic              pop_valid_o
);
    stack_state_t st_d, st_q;
    logic         pop_en;
    logic [DATA_W-1:0] sp_up;

    always_comb begin
        st_d        = st_q;
        pop_en      = pop_i && !push_i;
        sp_up       = st_q.sp + 1'b1;
        mem_we_o    = push_i;
        mem_re_o    = pop_en;
        mem_wdata_o = push_data_i;
        mem_addr_o  = {STACK_PAGE, pop_en ? sp_up : st_q.sp};
        st_d.pop_valid = pop_en;
        if (push_i) begin
            st_d.sp = st_q.sp - 1'b1;
        end else if (pop_en) begin
            st_d.sp       = sp_up;
            st_d.pop_data = mem_rdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{sp: SP_RESET, pop_data: '0, pop_valid: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign sp_o        = st_q.sp;
    assign pop_data_o  = st_q.pop_data;
    assign pop_valid_o = st_q.pop_valid;
endmodule

// File: rtl/peu_pc_lane.sv
module peu_pc_lane
    import post_exec_update_pkg::*;
#(
    parameter logic [ADDR_W-1:0] PC_RESET = 16'h0000,
    parameter int                SIZE_W   = 2,
    parameter int                BR_LEN   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv_i,
    input  logic [SIZE_W-1:0] adv_size_i,
    input  logic              branch_i,
    input  logic [DATA_W-1:0] br_off_i,
    output logic [ADDR_W-1:0] pc_o
);
    localparam int EXT_W = ADDR_W - DATA_W;
    localparam logic [ADDR_W-1:0] BR_LEN_V = ADDR_W'(BR_LEN);

    pc_state_t pc_d, pc_q;
    logic [ADDR_W-1:0] off_ext;

    always_comb begin
        pc_d    = pc_q;
        off_ext = {{EXT_W{br_off_i[DATA_W-1]}}, br_off_i};
        if (branch_i) begin
            pc_d.pc = pc_q.pc + off_ext + BR_LEN_V;
        end else if (adv_i) begin
            pc_d.pc = pc_q.pc + ADDR_W'(adv_size_i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q <= '{pc: PC_RESET};
        end else begin
            pc_q <= pc_d;
        end
    end

    assign pc_o = pc_q.pc;
endmodule

// File: rtl/peu_flag_lane.sv
module peu_flag_lane
    import post_exec_update_pkg::*;
#(
    parameter logic [DATA_W-1:0] STATUS_RESET = 8'h00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flag_upd_i,
    input  logic [DATA_W-1:0] result_i,
    output logic [DATA_W-1:0] status_o
);
    flag_state_t fl_d, fl_q;

    always_comb begin
        fl_d = fl_q;
        if (flag_upd_i) begin
            fl_d.status[Z_BIT] = (result_i == '0);
            fl_d.status[N_BIT] = result_i[DATA_W-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fl_q <= '{status: STATUS_RESET};
        end else begin
            fl_q <= fl_d;
        end
    end

    assign status_o = fl_q.status;
endmodule

// File: rtl/post_exec_update.sv
module post_exec_update
    import post_exec_update_pkg::*;
#(
    parameter logic [7:0]  STACK_PAGE = 8'h01,
    parameter logic [7:0]  SP_RESET   = 8'hFF,
    parameter logic [15:0] PC_RESET   = 16'h0000,
    parameter int          SIZE_W     = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        push_i,
    input  logic        pop_i,
    input  logic [7:0]  push_data_i,
    input  logic        adv_i,
    input  logic [SIZE_W-1:0] adv_size_i,
    input  logic        branch_i,
    input  logic [7:0]  br_off_i,
    input  logic        flag_upd_i,
    input  logic [7:0]  result_i,
    output logic [15:0] mem_addr_o,
    output logic        mem_we_o,
    output logic        mem_re_o,
    output logic [7:0]  mem_wdata_o,
    input  logic [7:0]  mem_rdata_i,
    output logic [7:0]  sp_o,
    output logic [15:0] pc_o,
    output logic [7:0]  status_o,
    output logic [7:0]  pop_data_o,
    output logic        pop_valid_o
);
    peu_stack_lane #(
        .STACK_PAGE(STACK_PAGE),
        .SP_RESET  (SP_RESET)
    ) u_stack (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_i     (push_i),
        .pop_i      (pop_i),
        .push_data_i(push_data_i),
        .mem_rdata_i(mem_rdata_i),
        .mem_addr_o (mem_addr_o),
        .mem_we_o   (mem_we_o),
        .mem_re_o   (mem_re_o),
        .mem_wdata_o(mem_wdata_o),
        .sp_o       (sp_o),
        .pop_data_o (pop_data_o),
        .pop_valid_o(pop_valid_o)
    );

    peu_pc_lane #(
        .PC_RESET(PC_RESET),
        .SIZE_W  (SIZE_W),
        .BR_LEN  (2)
    ) u_pc (
        .clk       (clk),
        .rst_n     (rst_n),
        .adv_i     (adv_i),
        .adv_size_i(adv_size_i),
        .branch_i  (branch_i),
        .br_off_i  (br_off_i),
        .pc_o      (pc_o)
    );

    peu_flag_lane #(
        .STATUS_RESET(8'h00)
    ) u_flag (
        .clk       (clk),
        .rst_n     (rst_n),
        .flag_upd_i(flag_upd_i),
        .result_i  (result_i),
        .status_o  (status_o)
    );
endmodule

// File: rtl/post_exec_update_chk.sv
module post_exec_update_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        push_i,
    input logic        pop_i,
    input logic        adv_i,
    input logic [1:0]  adv_size_i,
    input logic        branch_i,
    input logic [7:0]  br_off_i,
    input logic        flag_upd_i,
    input logic [7:0]  result_i,
    input logic [15:0] mem_addr_o,
    input logic        mem_we_o,
    input logic        mem_re_o,
    input logic [7:0]  sp_o,
    input logic [15:0] pc_o,
    input logic [7:0]  status_o,
    input logic        pop_valid_o
);
    p_push_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |-> (mem_we_o && mem_addr_o == {8'h01, sp_o}));

    p_push_dec_r2: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |=> (sp_o == 8'($past(sp_o) - 8'd1)));

    p_pop_inc_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i) |=> (pop_valid_o && sp_o == 8'($past(sp_o) + 8'd1)));

    p_one_access_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we_o && mem_re_o));

    p_push_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && pop_i) |-> !mem_re_o);

    p_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && !branch_i) |=> (pc_o == 16'($past(pc_o) + {14'd0, $past(adv_size_i)})));

    p_branch_r7: assert property (@(posedge clk) disable iff (!rst_n)
        branch_i |=> (pc_o == 16'($past(pc_o) + {{8{$past(br_off_i[7])}}, $past(br_off_i)} + 16'd2)));

    p_hold_pc_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv_i && !branch_i) |=> $stable(pc_o));

    p_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_upd_i && result_i == 8'h00) |=> status_o[1]);

    p_neg_r11: assert property (@(posedge clk) disable iff (!rst_n)
        flag_upd_i |=> (status_o[7] == $past(result_i[7])));

    p_other_bits_r12: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_o & 8'h7D) == ($past(status_o) & 8'h7D)));

    p_no_upd_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_upd_i |=> $stable(status_o));
endmodule

bind post_exec_update post_exec_update_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_i     (push_i),
    .pop_i      (pop_i),
    .adv_i      (adv_i),
    .adv_size_i (adv_size_i),
    .branch_i   (branch_i),
    .br_off_i   (br_off_i),
    .flag_upd_i (flag_upd_i),
    .result_i   (result_i),
    .mem_addr_o (mem_addr_o),
    .mem_we_o   (mem_we_o),
    .mem_re_o   (mem_re_o),
    .sp_o       (sp_o),
    .pc_o       (pc_o),
    .status_o   (status_o),
    .pop_valid_o(pop_valid_o)
);

// File: tb/post_exec_update_test.sv
`timescale 1ns/1ps
module post_exec_update_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        push_i = 0, pop_i = 0, adv_i = 0, branch_i = 0, flag_upd_i = 0;
    logic [7:0]  push_data_i = 0, br_off_i = 0, result_i = 0;
    logic [1:0]  adv_size_i = 0;
    logic [15:0] mem_addr_o;
    logic        mem_we_o, mem_re_o;
    logic [7:0]  mem_wdata_o, mem_rdata_i;
    logic [7:0]  sp_o, status_o, pop_data_o;
    logic [15:0] pc_o;
    logic        pop_valid_o;

    always #4 clk = ~clk;

    post_exec_update uut (
        .clk(clk), .rst_n(rst_n),
        .push_i(push_i), .pop_i(pop_i), .push_data_i(push_data_i),
        .adv_i(adv_i), .adv_size_i(adv_size_i),
        .branch_i(branch_i), .br_off_i(br_off_i),
        .flag_upd_i(flag_upd_i), .result_i(result_i),
        .mem_addr_o(mem_addr_o), .mem_we_o(mem_we_o), .mem_re_o(mem_re_o),
        .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i),
        .sp_o(sp_o), .pc_o(pc_o), .status_o(status_o),
        .pop_data_o(pop_data_o), .pop_valid_o(pop_valid_o)
    );

    logic [7:0] ram [0:511];
    assign mem_rdata_i = ram[mem_addr_o[8:0]];
    always @(posedge clk) if (mem_we_o) ram[mem_addr_o[8:0]] <= mem_wdata_o;

    int vectors = 0;
    int miscompares = 0;
    bit done = 0;

    int sp_m, pc_m;
    logic [7:0] st_m, pd_m;
    bit pv_m;
    logic [7:0] mstk [0:255];
    string last_tag = "R1";

    task automatic chk(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_regs();
        chk({last_tag, " sp"},        sp_o,        sp_m);
        chk({last_tag, " pc"},        pc_o,        pc_m);
        chk({last_tag, " status"},    status_o,    st_m);
        chk({last_tag, " pop_valid"}, pop_valid_o, pv_m);
        chk({last_tag, " pop_data"},  pop_data_o,  pd_m);
    endtask

    // one cycle: drive at falling edge, check comb outputs, update model after rising edge
    task automatic cyc(input string tag, input bit pu, input bit po, input logic [7:0] pdat,
                       input bit ad, input logic [1:0] sz, input bit br, input logic [7:0] off,
                       input bit fl, input logic [7:0] res);
        int a;
        @(negedge clk);
        check_regs();
        push_i = pu; pop_i = po; push_data_i = pdat;
        adv_i = ad; adv_size_i = sz; branch_i = br; br_off_i = off;
        flag_upd_i = fl; result_i = res;
        #1;
        chk({tag, " R2 we"}, mem_we_o, pu);
        chk({tag, " R5 re"}, mem_re_o, po && !pu);
        if (pu) begin
            chk({tag, " R2 addr"}, mem_addr_o, 16'h0100 + sp_m);
            chk({tag, " R2 wdata"}, mem_wdata_o, pdat);
        end else if (po) begin
            chk({tag, " R3 addr"}, mem_addr_o, 16'h0100 + ((sp_m + 1) & 255));
        end
        @(posedge clk);
        if (pu) begin
            mstk[sp_m] = pdat;
            sp_m = (sp_m - 1) & 255;
            pv_m = 0;
        end else if (po) begin
            sp_m = (sp_m + 1) & 255;
            pd_m = mstk[sp_m];
            pv_m = 1;
        end else begin
            pv_m = 0;
        end
        if (br) begin
            a = $signed(off);
            pc_m = (pc_m + a + 2) & 16'hFFFF;
        end else if (ad) begin
            pc_m = (pc_m + sz) & 16'hFFFF;
        end
        if (fl) begin
            st_m[1] = (res == 8'h00);
            st_m[7] = res[7];
        end
        last_tag = tag;
    endtask

    task automatic idle(input string tag);
        cyc(tag, 0, 0, 8'h00, 0, 2'd0, 0, 8'h00, 0, 8'h00);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            miscompares++;
            vectors++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 512; i++) ram[i] = 8'h00;
        for (int i = 0; i < 256; i++) mstk[i] = 8'h00;
        sp_m = 8'hFF; pc_m = 0; st_m = 8'h00; pd_m = 8'h00; pv_m = 0;
        repeat (2) @(negedge clk);
        // R1: reset values
        chk("R1 sp", sp_o, 8'hFF);
        chk("R1 pc", pc_o, 16'h0000);
        chk("R1 status", status_o, 8'h00);
        chk("R1 pop_valid", pop_valid_o, 0);
        chk("R1 pop_data", pop_data_o, 0);
        rst_n = 1'b1;
        idle("R1");
        // R2 pushes, R3 pops
        cyc("R2", 1, 0, 8'hA1, 0, 0, 0, 0, 0, 0);
        cyc("R2", 1, 0, 8'hB2, 0, 0, 0, 0, 0, 0);
        cyc("R2", 1, 0, 8'hC3, 0, 0, 0, 0, 0, 0);
        cyc("R3", 0, 1, 8'h00, 0, 0, 0, 0, 0, 0);
        cyc("R3", 0, 1, 8'h00, 0, 0, 0, 0, 0, 0);
        idle("R3");
        cyc("R3", 0, 1, 8'h00, 0, 0, 0, 0, 0, 0);
        // R4: pop at 0xFF wraps to 0x00, then push back
        cyc("R4", 0, 1, 8'h00, 0, 0, 0, 0, 0, 0);
        cyc("R4", 1, 0, 8'h5E, 0, 0, 0, 0, 0, 0);
        // R4: drive SP down through 0x00
        for (int i = 0; i < 257; i++) cyc("R4", 1, 0, 8'(i), 0, 0, 0, 0, 0, 0);
        for (int i = 0; i < 3; i++) cyc("R4", 0, 1, 8'h00, 0, 0, 0, 0, 0, 0);
        // R5: push and pop together
        cyc("R5", 1, 1, 8'h77, 0, 0, 0, 0, 0, 0);
        cyc("R5", 1, 1, 8'h78, 0, 0, 0, 0, 0, 0);
        idle("R5");
        // R6: steps of each size
        cyc("R6", 0, 0, 0, 1, 2'd1, 0, 0, 0, 0);
        cyc("R6", 0, 0, 0, 1, 2'd2, 0, 0, 0, 0);
        cyc("R6", 0, 0, 0, 1, 2'd3, 0, 0, 0, 0);
        cyc("R6", 0, 0, 0, 1, 2'd0, 0, 0, 0, 0);
        // R7: forward and backward branches
        cyc("R7", 0, 0, 0, 0, 2'd0, 1, 8'h05, 0, 0);
        cyc("R7", 0, 0, 0, 0, 2'd0, 1, 8'hFE, 0, 0);
        cyc("R7", 0, 0, 0, 0, 2'd0, 1, 8'h7F, 0, 0);
        // R8: branch beats step
        cyc("R8", 0, 0, 0, 1, 2'd3, 1, 8'h10, 0, 0);
        // R9: wrap below zero then above 0xFFFF
        for (int i = 0; i < 3; i++) cyc("R9", 0, 0, 0, 0, 2'd0, 1, 8'h80, 0, 0);
        for (int i = 0; i < 8; i++) cyc("R9", 0, 0, 0, 0, 2'd0, 1, 8'h7F, 0, 0);
        for (int i = 0; i < 40; i++) cyc("R9", 0, 0, 0, 1, 2'd3, 0, 0, 0, 0);
        // R10/R11/R12 flags
        cyc("R10", 0, 0, 0, 0, 0, 0, 0, 1, 8'h00);
        cyc("R11", 0, 0, 0, 0, 0, 0, 0, 1, 8'h80);
        cyc("R10", 0, 0, 0, 0, 0, 0, 0, 1, 8'h7F);
        cyc("R12", 0, 0, 0, 0, 0, 0, 0, 0, 8'h00);
        cyc("R11", 0, 0, 0, 0, 0, 0, 0, 1, 8'hFF);
        cyc("R12", 0, 0, 0, 0, 0, 0, 0, 0, 8'h00);
        // random mix of all lanes
        for (int i = 0; i < 600; i++) begin
            cyc("R12 mix", 1'($urandom), 1'($urandom), 8'($urandom),
                1'($urandom), 2'($urandom), 1'($urandom), 8'($urandom),
                1'($urandom), (($urandom % 4) == 0) ? 8'h00 : 8'($urandom));
        end
        idle("R3");
        @(negedge clk);
        check_regs();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule